// File: doc/BRIEF.md
# Triggered Event Sample Scheduler

This block decides when each of a small set of analog sampling events is handed to one of two converter interfaces. Two frame timers sit idle until their own trigger input shows the selected edge (for instance a PWM period pulse). The timer then counts converter-clock periods, marked by `aclk_en`. Every table entry is bound to one timer. An entry is issued to its interface when the bound timer's count reaches the entry's stored time.

Each entry holds a time, a timer select, an interface select, an 8-bit control word, a memory offset and a simultaneous-sample flag. Entries are loaded through a one-cycle write port. A timer halts by itself once every entry bound to it has been issued or dropped, and it reports that with a one-cycle frame-done pulse. Sticky status bits record a trigger that arrives before the frame has finished (overrun) and an entry whose time was already behind the count (miss). Software clears these bits by writing ones.

Top module: `evt_sched`

## Requirements
- R1: After reset, `req_vld`, `req_pair`, `frame_done`, `st_ovr` and `st_miss` are all 0, and both timers are idle.
- R2: Trigger edge is chosen per timer: `trig_pol[t]`=1 starts timer t on a rising edge of `trig_in[t]`, and 0 starts it on a falling edge. The opposite edge does nothing.
- R3: A valid entry with time T on timer t (`wr_tmr`=0 or 1) and interface i (`wr_if`=0 or 1) drives `req_vld[i]` high for one cycle. With `aclk_en` held high, this happens 2+T clock cycles after the cycle in which the trigger edge is sampled. `req_evt[i]`, `req_ctl[i]` and `req_off[i]` then carry the entry's index, control word and offset.
- R4: The timer count moves forward only in cycles where `aclk_en` is 1. While `aclk_en` is 0, no entry becomes due.
- R5: On one interface, at most one entry is issued per cycle. Among the due entries, those with the simultaneous flag go first, and within each group the lower index goes first. Each later entry follows in the next cycle.
- R6: Two entries with the simultaneous flag set, on different interfaces, on the same timer and with equal times, are issued in the same cycle with `req_pair` high on both interfaces.
- R7: The cycle after the last entry of a frame is issued, `frame_done[t]` pulses high for exactly one cycle and timer t stops. A later trigger then starts a new frame without any overrun.
- R8: A trigger edge on a timer that is still running sets the sticky bit `st_ovr[t]` and restarts that timer's frame from count zero.
- R9: An entry written while its timer is running, with a time below the current count, is never issued. On the next counting cycle it sets the sticky bit `st_miss[t]`.
- R10: Status bits stay set until cleared by a one-cycle `st_clr` strobe: bit t clears `st_ovr[t]` and bit 2+t clears `st_miss[t]`. A new set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| aclk_en | input | 1 | Converter-clock period enable, advances running timers |
| trig_in | input | 2 | Trigger input per timer |
| trig_pol | input | 2 | Edge select per timer, 1 rising, 0 falling |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | IW | Entry index to write |
| wr_vld | input | 1 | Entry in use |
| wr_time | input | TW | Event time in converter-clock periods |
| wr_tmr | input | 1 | Bound timer |
| wr_if | input | 1 | Target interface |
| wr_sim | input | 1 | Simultaneous-sample flag |
| wr_ctl | input | CW | Control word delivered with the request |
| wr_off | input | OW | Memory offset delivered with the request |
| st_clr | input | 4 | Write-one-to-clear: [1:0] overrun, [3:2] miss |
| req_vld | output | 2 | Request strobe per interface |
| req_pair | output | 2 | Request belongs to a simultaneous pair |
| req_evt | output | 2xIW | Issued entry index per interface |
| req_ctl | output | 2xCW | Issued control word per interface |
| req_off | output | 2xOW | Issued memory offset per interface |
| frame_done | output | 2 | One-cycle frame completion per timer |
| st_ovr | output | 2 | Sticky trigger overrun per timer |
| st_miss | output | 2 | Sticky event miss per timer |

## Verification
Three registers sit between a sampled trigger edge and a request: the timer start, the due latch and the output register. A request for time T therefore appears 2+T cycles after the trigger edge, and `frame_done` appears one cycle after the final request. Overrun appears in the cycle right after the offending edge, and a miss one counting cycle after the late write. The bench drives inputs on falling clock edges and advances by whole cycles to that falling edge. It then checks the cycle before each due result as well as the due cycle, so a result that arrives one cycle early or late fails.

// File: rtl/evt_sched.sv
module evt_sched #(
  parameter int N_EVT = 24,
  parameter int TW = 12,
  parameter int CW = 8,
  parameter int OW = 8,
  localparam int IW = $clog2(N_EVT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  aclk_en,
  input  logic [1:0]            trig_in,
  input  logic [1:0]            trig_pol,
  input  logic                  wr_en,
  input  logic [IW-1:0]         wr_idx,
  input  logic                  wr_vld,
  input  logic [TW-1:0]         wr_time,
  input  logic                  wr_tmr,
  input  logic                  wr_if,
  input  logic                  wr_sim,
  input  logic [CW-1:0]         wr_ctl,
  input  logic [OW-1:0]         wr_off,
  input  logic [3:0]            st_clr,
  output logic [1:0]            req_vld,
  output logic [1:0]            req_pair,
  output logic [1:0][IW-1:0]    req_evt,
  output logic [1:0][CW-1:0]    req_ctl,
  output logic [1:0][OW-1:0]    req_off,
  output logic [1:0]            frame_done,
  output logic [1:0]            st_ovr,
  output logic [1:0]            st_miss
);

  logic [N_EVT-1:0] e_vld, e_tmr, e_if, e_sim, pend, rdy;
  logic [TW-1:0]    e_time [N_EVT];
  logic [CW-1:0]    e_ctl  [N_EVT];
  logic [OW-1:0]    e_off  [N_EVT];

  logic [1:0]       trig_q, run, busy, fin, miss_t;
  logic [TW-1:0]    cnt [2];
  logic [N_EVT-1:0] hit, miss, iss, wr_hit;
  logic [1:0]       sel_ok, sel_sim;
  logic [IW-1:0]    sel [2];
  logic             pair;

  wire [1:0] trig_edge = (trig_in & ~trig_q & trig_pol) | (~trig_in & trig_q & ~trig_pol);

  assign busy[0] = |(pend & ~e_tmr);
  assign busy[1] = |(pend & e_tmr);
  assign fin     = run & ~busy & ~trig_edge;
  assign miss_t  = {|(miss & e_tmr), |(miss & ~e_tmr)};

  always_comb begin
    for (int e = 0; e < N_EVT; e++) begin
      wr_hit[e] = wr_en && (wr_idx == IW'(e));
      hit[e]  = aclk_en && run[e_tmr[e]] && pend[e] && !rdy[e] && !wr_hit[e] &&
                !trig_edge[e_tmr[e]] && (e_time[e] == cnt[e_tmr[e]]);
      miss[e] = aclk_en && run[e_tmr[e]] && pend[e] && !rdy[e] && !wr_hit[e] &&
                !trig_edge[e_tmr[e]] && (e_time[e] < cnt[e_tmr[e]]);
    end
  end

  always_comb begin
    iss = '0;
    for (int i = 0; i < 2; i++) begin
      logic s_ok, n_ok;
      logic [IW-1:0] s_idx, n_idx;
      s_ok = 1'b0; n_ok = 1'b0; s_idx = '0; n_idx = '0;
      for (int e = N_EVT - 1; e >= 0; e--) begin
        if (rdy[e] && (e_if[e] == 1'(i))) begin
          if (e_sim[e]) begin
            s_ok  = 1'b1;
            s_idx = IW'(e);
          end
          n_ok  = 1'b1;
          n_idx = IW'(e);
        end
      end
      sel_ok[i]  = n_ok;
      sel_sim[i] = s_ok;
      sel[i]     = s_ok ? s_idx : n_idx;
      for (int e = 0; e < N_EVT; e++)
        if (n_ok && (sel[i] == IW'(e))) iss[e] = 1'b1;
    end
    pair = &sel_ok && &sel_sim && (e_tmr[sel[0]] == e_tmr[sel[1]]) &&
           (e_time[sel[0]] == e_time[sel[1]]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_vld <= '0; e_tmr <= '0; e_if <= '0; e_sim <= '0;
      pend  <= '0; rdy   <= '0;
      for (int e = 0; e < N_EVT; e++) begin
        e_time[e] <= '0; e_ctl[e] <= '0; e_off[e] <= '0;
      end
    end else begin
      for (int e = 0; e < N_EVT; e++) begin
        if (wr_hit[e]) begin
          e_vld[e]  <= wr_vld;
          e_tmr[e]  <= wr_tmr;
          e_if[e]   <= wr_if;
          e_sim[e]  <= wr_sim;
          e_time[e] <= wr_time;
          e_ctl[e]  <= wr_ctl;
          e_off[e]  <= wr_off;
          pend[e]   <= wr_vld && (run[wr_tmr] || trig_edge[wr_tmr]);
          rdy[e]    <= 1'b0;
        end else if (trig_edge[e_tmr[e]]) begin
          pend[e] <= e_vld[e];
          rdy[e]  <= 1'b0;
        end else if (iss[e] || miss[e]) begin
          pend[e] <= 1'b0;
          rdy[e]  <= 1'b0;
        end else if (hit[e]) begin
          rdy[e] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0; run <= '0; frame_done <= '0; st_ovr <= '0; st_miss <= '0;
      cnt[0] <= '0; cnt[1] <= '0;
    end else begin
      trig_q     <= trig_in;
      frame_done <= fin;
      st_ovr     <= (st_ovr & ~st_clr[1:0]) | (trig_edge & run);
      st_miss    <= (st_miss & ~st_clr[3:2]) | miss_t;
      for (int t = 0; t < 2; t++) begin
        if (trig_edge[t]) begin
          run[t] <= 1'b1;
          cnt[t] <= '0;
        end else if (fin[t]) begin
          run[t] <= 1'b0;
        end else if (run[t] && aclk_en && (cnt[t] != '1)) begin
          cnt[t] <= cnt[t] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_vld <= '0; req_pair <= '0; req_evt <= '0; req_ctl <= '0; req_off <= '0;
    end else begin
      req_vld  <= sel_ok;
      req_pair <= {2{pair}};
      for (int i = 0; i < 2; i++) begin
        req_evt[i] <= sel[i];
        req_ctl[i] <= e_ctl[sel[i]];
        req_off[i] <= e_off[sel[i]];
      end
    end
  end

endmodule

// File: rtl/evt_sched_chk.sv
module evt_sched_chk #(
  parameter int IW = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         req_vld,
  input logic [1:0]         req_pair,
  input logic [1:0][IW-1:0] req_evt,
  input logic [1:0]         frame_done,
  input logic [1:0]         st_ovr,
  input logic [3:0]         st_clr
);

  p_pair_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_pair[0] |-> (req_vld == 2'b11) && req_pair[1]);

  p_done_pulse0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done[0] |=> !frame_done[0]);

  p_done_pulse1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done[1] |=> !frame_done[1]);

  p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ovr[0] && !st_clr[0]) |=> st_ovr[0]);

  p_one_per_cycle0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld[0] && $past(req_vld[0])) |-> (req_evt[0] != $past(req_evt[0])));

  p_one_per_cycle1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld[1] && $past(req_vld[1])) |-> (req_evt[1] != $past(req_evt[1])));

endmodule

bind evt_sched evt_sched_chk #(.IW(IW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_pair(req_pair),
  .req_evt(req_evt), .frame_done(frame_done), .st_ovr(st_ovr), .st_clr(st_clr)
);

// File: tb/evt_sched_tb.sv
module evt_sched_tb_top;
  localparam int N = 24;
  localparam int IW = $clog2(N);

  logic clk = 0, rst_n = 0, aclk_en = 1;
  logic [1:0] trig_in = 0, trig_pol = 2'b11;
  logic wr_en = 0, wr_vld = 0, wr_tmr = 0, wr_if = 0, wr_sim = 0;
  logic [IW-1:0] wr_idx = 0;
  logic [11:0] wr_time = 0;
  logic [7:0] wr_ctl = 0, wr_off = 0;
  logic [3:0] st_clr = 0;
  logic [1:0] req_vld, req_pair, frame_done, st_ovr, st_miss;
  logic [1:0][IW-1:0] req_evt;
  logic [1:0][7:0] req_ctl, req_off;

  int n_chk = 0, n_bad = 0, n_if1 = 0;

  always #5 clk = ~clk;

  evt_sched dut_i (.*);

  always @(negedge clk) if (req_vld[1]) n_if1++;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic wr(input int idx, input bit v, input int tm, input bit tmr,
                    input bit ifc, input bit sim, input int ctl, input int off);
    wr_en = 1; wr_idx = IW'(idx); wr_vld = v; wr_time = 12'(tm); wr_tmr = tmr;
    wr_if = ifc; wr_sim = sim; wr_ctl = 8'(ctl); wr_off = 8'(off);
    step(1);
    wr_en = 0;
  endtask

  task automatic clear_table;
    for (int e = 0; e < N; e++) wr(e, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic pulse(input int t);
    trig_in[t] = ~trig_in[t];
    step(1);
    trig_in[t] = ~trig_in[t];
  endtask

  task automatic t_reset;
    chk("R1 req_vld", req_vld, 0);
    chk("R1 frame_done", frame_done, 0);
    chk("R1 st_ovr", st_ovr, 0);
    chk("R1 st_miss", st_miss, 0);
  endtask

  task automatic t_fire;
    clear_table();
    wr(7, 1, 4, 1, 1, 0, 8'hA5, 8'h33);
    pulse(1);
    step(5);
    chk("R3 early", req_vld[1], 0);
    step(1);
    chk("R3 vld", req_vld[1], 1);
    chk("R3 evt", req_evt[1], 7);
    chk("R3 ctl", req_ctl[1], 8'hA5);
    chk("R3 off", req_off[1], 8'h33);
    step(1);
    chk("R7 done", frame_done[1], 1);
    step(2);
  endtask

  task automatic t_polarity;
    clear_table();
    trig_pol[1] = 0;
    wr(2, 1, 0, 1, 0, 0, 1, 1);
    trig_in[1] = 1;
    step(4);
    chk("R2 wrong edge", req_vld[0], 0);
    chk("R2 wrong edge done", frame_done[1], 0);
    trig_in[1] = 0;
    step(3);
    chk("R2 falling edge fires", req_vld[0], 1);
    step(3);
    trig_pol[1] = 1;
    step(1);
  endtask

  task automatic t_aclk;
    clear_table();
    wr(4, 1, 1, 0, 0, 0, 9, 9);
    pulse(0);
    aclk_en = 0;
    step(5);
    chk("R4 held", req_vld[0], 0);
    aclk_en = 1;
    step(2);
    chk("R4 not yet", req_vld[0], 0);
    step(1);
    chk("R4 fires", req_vld[0], 1);
    step(3);
  endtask

  task automatic t_order;
    clear_table();
    wr(0, 1, 0, 0, 0, 0, 10, 0);
    wr(1, 1, 0, 0, 0, 1, 11, 0);
    wr(2, 1, 0, 0, 1, 1, 12, 0);
    pulse(0);
    step(2);
    chk("R6 vld both", req_vld, 3);
    chk("R6 pair", req_pair, 3);
    chk("R5 sim first", req_evt[0], 1);
    chk("R6 partner", req_evt[1], 2);
    step(1);
    chk("R5 next cycle", req_vld, 1);
    chk("R5 lower index", req_evt[0], 0);
    chk("R5 no pair", req_pair, 0);
    chk("R7 not done yet", frame_done[0], 0);
    step(1);
    chk("R7 done pulse", frame_done[0], 1);
    step(1);
    chk("R7 done one cycle", frame_done[0], 0);
    pulse(0);
    step(1);
    chk("R7 retrigger no ovr", st_ovr[0], 0);
    step(5);
  endtask

  task automatic t_overrun;
    clear_table();
    wr(9, 1, 40, 0, 0, 0, 3, 3);
    pulse(0);
    step(5);
    pulse(0);
    chk("R8 ovr set", st_ovr[0], 1);
    step(41);
    chk("R8 restart early", req_vld[0], 0);
    step(1);
    chk("R8 restart fires", req_vld[0], 1);
    st_clr = 4'b0001;
    step(1);
    st_clr = 0;
    chk("R10 ovr cleared", st_ovr[0], 0);
    step(3);
  endtask

  task automatic t_miss;
    int base;
    clear_table();
    wr(3, 1, 50, 1, 0, 0, 0, 0);
    pulse(1);
    step(20);
    base = n_if1;
    wr(5, 1, 3, 1, 1, 0, 0, 0);
    chk("R9 not yet", st_miss[1], 0);
    step(1);
    chk("R9 miss set", st_miss[1], 1);
    step(40);
    chk("R9 never issued", n_if1 - base, 0);
    chk("R10 miss sticky", st_miss[1], 1);
    st_clr = 4'b1000;
    step(1);
    st_clr = 0;
    chk("R10 miss cleared", st_miss[1], 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    t_reset();
    t_fire();
    t_polarity();
    t_aclk();
    t_order();
    t_overrun();
    t_miss();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule